// File: doc/BRIEF.md
# Accumulator-Index Teaching CPU Core

This block is a small multi-cycle 8-bit processor core intended for demonstration hardware, where every step of execution is meant to be slow enough to follow. It holds an 8-bit accumulator, an 8-bit index register, a carry flag, a zero flag and a 13-bit program counter. Program and data share one byte-wide synchronous memory. Every instruction is therefore fetched as two bytes in two separate cycles, followed by one data-access cycle and one execute cycle.

There are eight operations:
- The accumulator instructions (NOR, ADD, store) address memory at the instruction's base address plus the index register.
- The index-register instructions add from, or store to, the unindexed base address.
- The index NOR reads the byte the index register points at.
- Two conditional jumps test carry-clear and zero-clear.

A step-enable input freezes the core in its current cycle. An outside controller can use it to advance the core one cycle or one instruction (four cycles) at a time.

Top module: `acc_index_cpu`

## Requirements
- R1: After reset, PC, A, X, carry and zero are all 0, and the first fetch reads address 0. An instruction is two bytes in big-endian order. Bits 7:5 of the first byte are the opcode: 0 NOR, 1 ADD, 2 STA, 3 JCC, 4 NORX, 5 ADDX, 6 STX, 7 JNZ. Bits 4:0 of the first byte followed by the second byte form a 13-bit address field.
- R2: Each instruction takes four enabled cycles, in this order: high byte fetch, low byte fetch, data access, execute. Unless a jump is taken, the PC then advances by 2.
- R3: NOR sets A = ~(A | mem[field+X]) and leaves the carry flag unchanged.
- R4: ADD sets A = A + mem[field+X], and the carry flag takes the ninth bit of the sum.
- R5: STA writes A to mem[field+X]. The indexed address wraps modulo 2^13.
- R6: NORX sets X = ~(X | mem[X]), with X zero-extended to form the address. The address field has no effect.
- R7: ADDX sets X = X + mem[field] and the carry flag takes the ninth bit of the sum. STX writes X to mem[field]. Neither one adds the index.
- R8: JCC loads the PC with the address field when carry is 0. When carry is 1, the jump is not taken and carry is cleared.
- R9: JNZ loads the PC with the address field when the zero flag is 0, and otherwise falls through.
- R10: Every write to A or X sets the zero flag to (result == 0). Stores and jumps leave the zero flag unchanged.
- R11: While step_en is 0, the core's state does not change and mem_re and mem_we both stay 0.
- R12: mem_re and mem_we are never both 1. Read data is expected one clock after a cycle with mem_re high, and the memory holds mem_rdata while mem_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance enable; 0 freezes the core |
| mem_rdata | input | 8 | Read data from synchronous memory |
| mem_addr | output | 13 | Memory byte address |
| mem_wdata | output | 8 | Write data (A or X) |
| mem_we | output | 1 | Write strobe for this cycle |
| mem_re | output | 1 | Read strobe; data returns next cycle |

## Verification
Each instruction's register update lands on the fourth enabled rising edge after its fetch begins. A store's write strobe is on the port during the third cycle and reaches memory at the end of that cycle. Results are only visible through stores, so each scenario task runs a fixed budget of cycles, well beyond the last store of a program that finishes in a self-loop, and only then reads the bench memory on a falling edge. The reset and step-gating checks sample the address and strobe outputs on falling edges, so the values come from the register state after the preceding rising edge.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int DW  = 8;
  localparam int AW  = 13;
  localparam int OPW = 3;
  localparam int HIW = AW - DW;

  typedef enum logic [1:0] {
    ST_FETCH_HI, ST_FETCH_LO, ST_ACCESS, ST_EXEC
  } state_t;

  typedef enum logic [OPW-1:0] {
    OP_NOR, OP_ADD, OP_STA, OP_JCC, OP_NORX, OP_ADDX, OP_STX, OP_JNZ
  } op_t;

  function automatic logic [DW-1:0] f_nor(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return ~(a | b);
  endfunction

  function automatic logic [DW:0] f_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [AW-1:0] f_index(input logic [AW-1:0] base, input logic [DW-1:0] idx);
    return base + AW'(idx);
  endfunction

  function automatic logic f_is_read(input op_t op);
    return op inside {OP_NOR, OP_ADD, OP_NORX, OP_ADDX};
  endfunction

  function automatic logic f_is_store(input op_t op);
    return op inside {OP_STA, OP_STX};
  endfunction

  function automatic logic f_uses_x(input op_t op);
    return op inside {OP_NORX, OP_ADDX, OP_STX};
  endfunction
endpackage

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_en,
  output state_t state
);
  state_t state_nx;

  always_comb begin
    case (state)
      ST_FETCH_HI: state_nx = ST_FETCH_LO;
      ST_FETCH_LO: state_nx = ST_ACCESS;
      ST_ACCESS:   state_nx = ST_EXEC;
      default:     state_nx = ST_FETCH_HI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= ST_FETCH_HI;
    else if (step_en) state <= state_nx;
  end

  assert_hold_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> state == $past(state));

  assert_access_follows_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && state == ST_FETCH_LO) |=> state == ST_ACCESS);
endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  state_t        state,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re
);
  localparam logic [AW-1:0] PC_STEP = AW'(2);

  logic [AW-1:0] pc;
  logic [DW-1:0] acc, xr, ir_hi, ir_lo;
  logic          cf, zf;

  op_t           op;
  logic [AW-1:0] field, target, eff_addr;
  logic [DW-1:0] src, nor_res;
  logic [DW:0]   sum;

  // named internal events
  logic exec_fire, acc_wr, x_wr, jump_taken;

  assign op     = op_t'(ir_hi[DW-1 -: OPW]);
  assign field  = {ir_hi[HIW-1:0], mem_rdata};
  assign target = {ir_hi[HIW-1:0], ir_lo};

  always_comb begin
    if (op == OP_NORX)    eff_addr = AW'(xr);
    else if (f_uses_x(op)) eff_addr = field;
    else                   eff_addr = f_index(field, xr);
  end

  always_comb begin
    case (state)
      ST_FETCH_HI: mem_addr = pc;
      ST_FETCH_LO: mem_addr = pc + AW'(1);
      ST_ACCESS:   mem_addr = eff_addr;
      default:     mem_addr = pc;
    endcase
  end

  assign mem_re = step_en && ((state == ST_FETCH_HI) || (state == ST_FETCH_LO) ||
                              (state == ST_ACCESS && f_is_read(op)));
  assign mem_we = step_en && (state == ST_ACCESS) && f_is_store(op);
  assign mem_wdata = (op == OP_STX) ? xr : acc;

  assign src     = f_uses_x(op) ? xr : acc;
  assign nor_res = f_nor(src, mem_rdata);
  assign sum     = f_add(src, mem_rdata);

  assign exec_fire  = step_en && (state == ST_EXEC);
  assign acc_wr     = exec_fire && (op == OP_NOR || op == OP_ADD);
  assign x_wr       = exec_fire && (op == OP_NORX || op == OP_ADDX);
  assign jump_taken = exec_fire && ((op == OP_JCC && !cf) || (op == OP_JNZ && !zf));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; acc <= '0; xr <= '0; cf <= 1'b0; zf <= 1'b0;
      ir_hi <= '0; ir_lo <= '0;
    end else if (step_en) begin
      case (state)
        ST_FETCH_LO: ir_hi <= mem_rdata;
        ST_ACCESS:   ir_lo <= mem_rdata;
        ST_EXEC: begin
          pc <= jump_taken ? target : pc + PC_STEP;
          case (op)
            OP_NOR:  begin acc <= nor_res;      zf <= (nor_res == '0); end
            OP_ADD:  begin acc <= sum[DW-1:0];  zf <= (sum[DW-1:0] == '0); cf <= sum[DW]; end
            OP_NORX: begin xr  <= nor_res;      zf <= (nor_res == '0); end
            OP_ADDX: begin xr  <= sum[DW-1:0];  zf <= (sum[DW-1:0] == '0); cf <= sum[DW]; end
            OP_JCC:  if (cf) cf <= 1'b0;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assert_pc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && !jump_taken) |=> pc == $past(pc) + PC_STEP);

  assert_nor_keeps_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && (op == OP_NOR || op == OP_NORX)) |=> cf == $past(cf));

  assert_jcc_clears_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && op == OP_JCC && cf) |=> !cf);

  assert_jump_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |=> pc == $past(target));

  assert_zero_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> zf == (acc == '0));

  assert_zero_x_R10: assert property (@(posedge clk) disable iff (!rst_n)
    x_wr |=> zf == (xr == '0));

  assert_store_keeps_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && f_is_store(op)) |=> zf == $past(zf));

  assert_quiet_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |-> (!mem_re && !mem_we));

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
endmodule

// File: rtl/acc_index_cpu.sv
module acc_index_cpu
  import cpu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re
);
  state_t state;

  cpu_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .state   (state)
  );

  cpu_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .state     (state),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
  );

  assert_first_fetch_R1: assert property (@(posedge clk)
    !rst_n |=> (mem_addr == '0 && !mem_we));
endmodule

// File: tb/sim_acc_index_cpu.sv
`timescale 1ns/1ps
module sim_acc_index_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b1;
  logic [7:0]  mem_rdata;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re;

  logic [7:0] mem [0:511];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  acc_index_cpu u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re)
  );

  // synchronous memory: data one clock after a read strobe, held otherwise
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[8:0]];
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  endtask

  // encoding: byte0 = {op[2:0], addr[12:8]}, byte1 = addr[7:0]
  task automatic put(input int pc, input int op, input int addr);
    mem[pc]     = {op[2:0], addr[12:8]};
    mem[pc + 1] = addr[7:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; step_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_mem();
    put(0, 3, 0);
    do_reset();
    chk("R1 reset addr", mem_addr, 0);
    chk("R1 reset re", mem_re, 1);
    chk("R12 reset we", mem_we, 0);
    run(1);
    chk("R2 second fetch addr", mem_addr, 1);
  endtask

  task automatic t_nor_sta();
    clear_mem();
    mem[9'h100] = 8'h0F;
    put(0, 0, 'h100);   // NOR
    put(2, 2, 'h180);   // STA
    put(4, 3, 4);       // JCC self
    do_reset(); run(60);
    chk("R3 nor with A=0", mem[9'h180], 8'hF0);
  endtask

  task automatic t_add_jcc();
    clear_mem();
    mem[9'h100] = 8'hF0; mem[9'h101] = 8'h20;
    put(0, 1, 'h100);   // ADD -> F0, C=0
    put(2, 1, 'h101);   // ADD -> 10, C=1
    put(4, 3, 'h40);    // JCC not taken, clears C
    put(6, 2, 'h180);   // STA
    put(8, 3, 'h40);    // JCC taken
    put('h40, 2, 'h181);
    put('h42, 3, 'h40);
    do_reset(); run(100);
    chk("R4 add carry wrap", mem[9'h180], 8'h10);
    chk("R8 jcc after clear", mem[9'h181], 8'h10);
  endtask

  task automatic t_indexed();
    clear_mem();
    mem[9'h100] = 8'h11; mem[9'h102] = 8'h03; mem[9'h103] = 8'h55;
    put(0, 5, 'h102);   // ADDX -> X=3
    put(2, 1, 'h100);   // ADD mem[103]
    put(4, 2, 'h180);   // STA -> 183
    put(6, 6, 'h190);   // STX unindexed
    put(8, 3, 8);
    do_reset();
    run(6);
    step_en = 1'b0;
    begin
      logic [12:0] held;
      held = mem_addr;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        chk("R11 addr held", mem_addr, held);
        chk("R11 no strobe", {mem_re, mem_we}, 0);
      end
    end
    step_en = 1'b1;
    run(80);
    chk("R5 indexed store", mem[9'h183], 8'h55);
    chk("R5 base untouched", mem[9'h180], 8'h00);
    chk("R7 stx unindexed", mem[9'h190], 8'h03);
  endtask

  task automatic t_norx();
    clear_mem();
    mem[9'h102] = 8'h10; mem[9'h010] = 8'h21; mem[9'h100] = 8'hAA;
    put(0, 5, 'h102);   // ADDX -> X=10
    put(2, 4, 'h100);   // NORX, field ignored
    put(4, 6, 'h190);
    put(6, 3, 6);
    do_reset(); run(80);
    chk("R6 norx reads mem[X]", mem[9'h190], 8'hCE);
  endtask

  task automatic t_jnz();
    clear_mem();
    mem[9'h101] = 8'h07;
    put(0, 1, 'h100);   // ADD 0 -> Z=1
    put(2, 7, 'h40);    // JNZ not taken
    put(4, 5, 'h101);   // ADDX -> 7, Z=0
    put(6, 6, 'h190);   // STX
    put(8, 7, 'h40);    // JNZ taken
    put('h40, 6, 'h191);
    put('h42, 7, 'h40);
    do_reset(); run(100);
    chk("R9 jnz falls through on zero", mem[9'h190], 8'h07);
    chk("R10 store keeps zero, jnz taken", mem[9'h191], 8'h07);
  endtask

  task automatic t_nor_carry();
    clear_mem();
    mem[9'h100] = 8'hFF; mem[9'h101] = 8'h01; mem[9'h102] = 8'h0F;
    put(0, 1, 'h100);   // A=FF
    put(2, 1, 'h101);   // A=00, C=1
    put(4, 0, 'h102);   // NOR -> F0, C kept
    put(6, 3, 'h40);    // not taken
    put(8, 2, 'h180);
    put(10, 3, 'h40);
    put('h40, 2, 'h181);
    put('h42, 3, 'h40);
    do_reset(); run(110);
    chk("R3 nor keeps carry", mem[9'h180], 8'hF0);
    chk("R8 second jcc taken", mem[9'h181], 8'hF0);
  endtask

  task automatic t_wrap();
    clear_mem();
    mem[9'h102] = 8'h03; mem[9'h107] = 8'h66;
    put(0, 5, 'h102);   // X=3
    put(2, 1, 'h104);   // A=66
    put(4, 2, 'h1FFE);  // STA -> 0x0001
    put(6, 3, 6);
    do_reset(); run(60);
    chk("R5 address wraps", mem[1], 8'h66);
  endtask

  initial begin
    mem_rdata = 8'h00;
    t_reset();
    t_nor_sta();
    t_add_jcc();
    t_indexed();
    t_norx();
    t_jnz();
    t_nor_carry();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog got=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule